// File: doc/BRIEF.md
# Wait-State Memory Bus Sequencer

This block runs one external data-memory read or write on a multiplexed address/data bus for a CPU core. Time is counted in T-states, one clock each. An access opens with an address-latch phase. A read or write strobe follows, and a single recovery T-state closes the access. The length of the strobe comes from two configured wait counts: one for data memory and one for instruction memory. For reads, an optional extra-T-state mode adds a bus turnaround T-state before the strobe.

An external active-low wait input holds a strobe that is about to end. An active-low lock input keeps the sequencer from starting new accesses. The core starts an access with a request level. The sequencer acknowledges it with a one-T-state done pulse in the T-state in which the strobe has returned high, and read data is valid alongside that pulse. The configuration, the remote-wait count, the address and the write data are all sampled in the T-state that accepts the request.

Top module: `membus_seq`

## Requirements
- R1: Reset leaves both strobes high, address latch enable low, the bus output enable low (bus released) and done low.
- R2: After acceptance, address latch enable is high for (rmt_wait+1) consecutive T-states. During those T-states the bus drives the request address with the output enable high.
- R3: For writes, and for reads with cfg_xt=0, the strobe is low for max(cfg_dw, cfg_iw−1)+1 T-states, where cfg_iw−1 saturates at 0. It follows the last latch-enable T-state directly.
- R4: For a read with cfg_xt=1, one turnaround T-state sits between the latch phase and the strobe: all strobes are high, latch enable is low and the bus is released. The read strobe is then low for max(cfg_dw−1, cfg_iw−1)+1 T-states, with each subtraction saturating at 0.
- R5: The bus output enable is low while the read strobe is low. rdata holds the bus input value sampled in the final read-strobe T-state and is valid while done is high.
- R6: During the write strobe the output enable is high and the bus carries the write data.
- R7: done is high for exactly one T-state, the one right after the final strobe T-state. In that T-state all strobes are high. With all counts zero, an access lasts 3 T-states, or 4 for a read with cfg_xt=1.
- R8: wait_n low at the clock edge that would end the strobe keeps the strobe low. If wait_n is low for the first L edges of the strobe, the strobe lasts max(S, L+1) T-states, where S is the length set by R3 or R4.
- R9: No access starts while lock_n is low, even with req high. An access already under way completes even if lock_n falls during it.
- R10: The read and write strobes are never low together, and neither is low while address latch enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | T-state clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_dw | input | 3 | Data-memory wait count |
| cfg_iw | input | 3 | Instruction-memory wait count |
| cfg_xt | input | 1 | Extra turnaround T-state for reads |
| rmt_wait | input | 3 | Extra latch-phase T-states from a pending remote access |
| req | input | 1 | Access request level from the core |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 16 | Write data |
| done | output | 1 | One-T-state access completion pulse |
| rdata | output | 16 | Read data, valid with done |
| lock_n | input | 1 | Active-low lock; blocks new accesses |
| wait_n | input | 1 | Active-low wait; stretches the strobe |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| ad_out | output | 16 | Bus output value |
| ad_oe | output | 1 | Bus output enable |
| ad_in | input | 16 | Bus input value |

## Verification
The two functions that can coincide are the wait stretch and the end of the programmed strobe length. wait_n can be low at the very edge where the wait-count timer expires, or it can be released before that edge. The bench sweeps the wait hold length L across values below, equal to and above the programmed length, for both long and short strobes. Each result is judged against max(S, L+1) measured at the strobe pins, and read data is checked at the moment done appears. A second coincidence, lock falling during an access that is already running, is judged by confirming that done still arrives.

// File: rtl/membus_pkg.sv
// Shared types and widths for the wait-state bus sequencer.
// Assumes one clock per T-state; no sub-cycle placement is modelled.
package membus_pkg;
    localparam int WAIT_W = 3;
    localparam int CNT_W  = WAIT_W + 1;

    typedef enum logic [2:0] {
        SQ_IDLE = 3'd0,
        SQ_ADDR = 3'd1,
        SQ_TURN = 3'd2,
        SQ_STRB = 3'd3,
        SQ_REC  = 3'd4
    } seq_st_t;
endpackage

// File: rtl/membus_len_calc.sv
// Strobe length calculator.
// Computes the strobe length in T-states from the two wait counts, the
// extra-T-state mode and the access direction. Pure combinational logic.
// Assumes the counts are unsigned; each "minus one" saturates at zero.
module membus_len_calc #(
    parameter int WAIT_W = 3,
    localparam int LEN_W = WAIT_W + 1
) (
    input  logic [WAIT_W-1:0] dw,
    input  logic [WAIT_W-1:0] iw,
    input  logic              xt,
    input  logic              is_wr,
    output logic [LEN_W-1:0]  len
);
    logic [WAIT_W-1:0] dw_m1;
    logic [WAIT_W-1:0] iw_m1;
    logic [WAIT_W-1:0] pick_d;
    logic [WAIT_W-1:0] base;

    // Saturating decrements and selection of the larger term.
    always_comb begin
        dw_m1  = (dw == '0) ? '0 : dw - 1'b1;
        iw_m1  = (iw == '0) ? '0 : iw - 1'b1;
        pick_d = (xt && !is_wr) ? dw_m1 : dw;
        base   = (pick_d > iw_m1) ? pick_d : iw_m1;
        len    = {1'b0, base} + 1'b1;
    end
endmodule

// File: rtl/membus_ctrl.sv
// Access sequencer state machine.
// Walks IDLE -> ADDR -> (TURN) -> STRB -> REC -> IDLE. The configuration
// (strobe length, remote-wait count, turnaround need) is captured on
// acceptance. Assumes req stays high until done and falls right after.
module membus_ctrl
    import membus_pkg::*;
#(
    parameter int WAIT_W = 3,
    localparam int CW    = WAIT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_wr,
    input  logic              xt,
    input  logic              lock_n,
    input  logic              wait_n,
    input  logic [WAIT_W-1:0] rmt_wait,
    input  logic [CW-1:0]     len,
    output seq_st_t           st,
    output logic              op_wr,
    output logic              accept,
    output logic              strb_end
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] slen_q;
    logic          turn_q;

    // Request acceptance and final-strobe-edge detection.
    always_comb begin
        accept   = (st == SQ_IDLE) && req && lock_n;
        strb_end = (st == SQ_STRB) && (cnt == '0) && wait_n;
    end

    // State register and T-state counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= SQ_IDLE;
            cnt    <= '0;
            slen_q <= '0;
            turn_q <= 1'b0;
            op_wr  <= 1'b0;
        end else begin
            case (st)
                SQ_IDLE: begin
                    if (accept) begin
                        st     <= SQ_ADDR;
                        cnt    <= {1'b0, rmt_wait};
                        slen_q <= len;
                        turn_q <= xt && !req_wr;
                        op_wr  <= req_wr;
                    end
                end
                SQ_ADDR: begin
                    if (cnt == '0) begin
                        st  <= turn_q ? SQ_TURN : SQ_STRB;
                        cnt <= slen_q - 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                SQ_TURN: st <= SQ_STRB;
                SQ_STRB: begin
                    if (cnt != '0)  cnt <= cnt - 1'b1;
                    else if (wait_n) st <= SQ_REC;
                end
                SQ_REC:  st <= SQ_IDLE;
                default: st <= SQ_IDLE;
            endcase
        end
    end

    // R9: a locked idle sequencer stays idle.
    assert_lock_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_IDLE && !lock_n) |=> (st == SQ_IDLE));

    // R8: wait low at the final strobe edge keeps the strobe phase.
    assert_wait_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_STRB && cnt == '0 && !wait_n) |=> (st == SQ_STRB));

    // R7: recovery lasts a single T-state.
    assert_rec_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_REC) |=> (st == SQ_IDLE));
endmodule

// File: rtl/membus_drv.sv
// Bus pin driver.
// Holds the address and write data captured on acceptance, decodes the
// strobes, latch enable and output enable from the sequencer state, and
// captures read data on the final read-strobe edge.
module membus_drv
    import membus_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  seq_st_t          st,
    input  logic             op_wr,
    input  logic             accept,
    input  logic             strb_end,
    input  logic [BUS_W-1:0] req_addr,
    input  logic [BUS_W-1:0] req_wdata,
    input  logic [BUS_W-1:0] ad_in,
    output logic             ale,
    output logic             rd_n,
    output logic             wr_n,
    output logic             ad_oe,
    output logic [BUS_W-1:0] ad_out,
    output logic             done,
    output logic [BUS_W-1:0] rdata
);
    logic [BUS_W-1:0] addr_q;
    logic [BUS_W-1:0] wdata_q;

    // Capture address and write data when an access is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Sample the bus on the edge that ends a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                  rdata <= '0;
        else if (strb_end && !op_wr) rdata <= ad_in;
    end

    // Pin decode from the sequencer state.
    always_comb begin
        ale    = (st == SQ_ADDR);
        rd_n   = !((st == SQ_STRB) && !op_wr);
        wr_n   = !((st == SQ_STRB) && op_wr);
        ad_oe  = (st == SQ_ADDR) || ((st == SQ_STRB) && op_wr);
        ad_out = (st == SQ_ADDR) ? addr_q : wdata_q;
        done   = (st == SQ_REC);
    end

    // R10: at most one strobe low at any time.
    assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> wr_n);

    // R10: latch enable never overlaps a strobe.
    assert_ale_apart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (rd_n && wr_n));

    // R5: bus released during a read strobe.
    assert_rd_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    // R7: done is a single-T-state pulse.
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/membus_seq.sv
// Top level of the wait-state memory bus sequencer.
// Ties the length calculator, the sequencer and the pin driver together.
// Assumes configuration inputs are static while a request is pending.
module membus_seq
    import membus_pkg::*;
#(
    parameter int BUS_W  = 16,
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WAIT_W-1:0] cfg_dw,
    input  logic [WAIT_W-1:0] cfg_iw,
    input  logic              cfg_xt,
    input  logic [WAIT_W-1:0] rmt_wait,
    input  logic              req,
    input  logic              req_wr,
    input  logic [BUS_W-1:0]  req_addr,
    input  logic [BUS_W-1:0]  req_wdata,
    output logic              done,
    output logic [BUS_W-1:0]  rdata,
    input  logic              lock_n,
    input  logic              wait_n,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic [BUS_W-1:0]  ad_out,
    output logic              ad_oe,
    input  logic [BUS_W-1:0]  ad_in
);
    localparam int CW = WAIT_W + 1;

    logic [CW-1:0] len;
    seq_st_t       st;
    logic          op_wr;
    logic          accept;
    logic          strb_end;

    membus_len_calc #(.WAIT_W(WAIT_W)) u_len (
        .dw(cfg_dw), .iw(cfg_iw), .xt(cfg_xt), .is_wr(req_wr), .len(len)
    );

    membus_ctrl #(.WAIT_W(WAIT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .xt(cfg_xt),
        .lock_n(lock_n), .wait_n(wait_n), .rmt_wait(rmt_wait), .len(len),
        .st(st), .op_wr(op_wr), .accept(accept), .strb_end(strb_end)
    );

    membus_drv #(.BUS_W(BUS_W)) u_drv (
        .clk(clk), .rst_n(rst_n), .st(st), .op_wr(op_wr), .accept(accept),
        .strb_end(strb_end), .req_addr(req_addr), .req_wdata(req_wdata),
        .ad_in(ad_in), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .ad_oe(ad_oe),
        .ad_out(ad_out), .done(done), .rdata(rdata)
    );
endmodule

// File: tb/membus_seq_bench.sv
// Sweep bench for membus_seq: every wait-count pair, both modes and both
// directions, plus wait-stretch and lock scenarios.
module membus_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_dw = '0, cfg_iw = '0, rmt_wait = '0;
    logic        cfg_xt = 1'b0, req = 1'b0, req_wr = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic        done, ale, rd_n, wr_n, ad_oe;
    logic [15:0] rdata, ad_out, ad_in;
    logic        lock_n = 1'b1, wait_n = 1'b1;
    logic [15:0] bus_addr = '0;
    int          total = 0, bad = 0;

    localparam logic [15:0] MASK = 16'h5A3C;
    assign ad_in = bus_addr ^ MASK;

    always #4 clk = ~clk;

    membus_seq u_membus_seq (
        .clk(clk), .rst_n(rst_n), .cfg_dw(cfg_dw), .cfg_iw(cfg_iw),
        .cfg_xt(cfg_xt), .rmt_wait(rmt_wait), .req(req), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata), .done(done),
        .rdata(rdata), .lock_n(lock_n), .wait_n(wait_n), .ale(ale),
        .rd_n(rd_n), .wr_n(wr_n), .ad_out(ad_out), .ad_oe(ad_oe),
        .ad_in(ad_in)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int sat1(input int v);
        return (v > 0) ? v - 1 : 0;
    endfunction

    function automatic int exp_len(input int dw, input int iw, input bit xt, input bit wr);
        int a;
        int b;
        a = (xt && !wr) ? sat1(dw) : dw;
        b = sat1(iw);
        return ((a > b) ? a : b) + 1;
    endfunction

    // One access; counts phases at negedges and checks R2..R8.
    task automatic run_access(input bit wr, input int dw, input int iw, input bit xt,
                              input int rw, input int wl, input bit lock_mid);
        int  n_ale = 0, n_gap = 0, n_strb = 0, iter = 0;
        bit  ok_addr = 1, ok_data = 1, ok_rel = 1, got_done = 0, ok_gap = 1;
        int  s_exp;
        logic [15:0] a, d;
        a = 16'(dw * 4099 + iw * 257 + rw * 31 + (xt ? 7 : 0) + (wr ? 3 : 0));
        d = ~a ^ 16'h1234;
        cfg_dw = 3'(dw); cfg_iw = 3'(iw); cfg_xt = xt; rmt_wait = 3'(rw);
        req_wr = wr; req_addr = a; req_wdata = d; req = 1'b1;
        s_exp = exp_len(dw, iw, xt, wr);
        if (wl + 1 > s_exp) s_exp = wl + 1;
        while (!got_done && iter < 100) begin
            @(posedge clk); #4;
            iter++;
            if (ale) begin
                n_ale++;
                bus_addr = ad_out;
                if (!(ad_oe && ad_out == a)) ok_addr = 0;
            end else if (!rd_n || !wr_n) begin
                n_strb++;
                if (n_strb == 1 && wl > 0) wait_n = 1'b0;
                if (n_strb == wl + 1) wait_n = 1'b1;
                if (n_strb == 1 && lock_mid) lock_n = 1'b0;
                if (!wr_n && !(ad_oe && ad_out == d)) ok_data = 0;
                if (!rd_n && ad_oe) ok_rel = 0;
            end else if (done) begin
                got_done = 1;
                req = 1'b0;
            end else if (n_ale > 0) begin
                n_gap++;
                if (ad_oe) ok_gap = 0;
            end
        end
        wait_n = 1'b1;
        chk(got_done, "R7 done seen", got_done, 1);
        chk(n_ale == rw + 1, "R2 ale length", n_ale, rw + 1);
        chk(ok_addr, "R2 address phase", ok_addr, 1);
        chk(n_gap == ((xt && !wr) ? 1 : 0) && ok_gap, "R4 turnaround", n_gap, (xt && !wr) ? 1 : 0);
        if (wl > 0)
            chk(n_strb == s_exp, "R8 stretched strobe", n_strb, s_exp);
        else if (xt && !wr)
            chk(n_strb == s_exp, "R4 xt read strobe", n_strb, s_exp);
        else
            chk(n_strb == s_exp, "R3 strobe length", n_strb, s_exp);
        if (wr) chk(ok_data, "R6 write data", ok_data, 1);
        else begin
            chk(ok_rel, "R5 bus released", ok_rel, 1);
            chk(rdata == (a ^ MASK), "R5 read data", int'(rdata), int'(a ^ MASK));
        end
        chk(rd_n && wr_n && !ale, "R7 strobes high with done", {rd_n, wr_n}, 3);
        @(posedge clk); #4;
        chk(!done, "R7 done pulse width", done, 0);
        if (lock_mid) lock_n = 1'b1;
    endtask

    initial begin
        #(8 * 190000);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total + 1, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #4;
        chk(rd_n && wr_n && !ale && !ad_oe && !done, "R1 reset state",
            {rd_n, wr_n, ale, ad_oe, done}, 5'b11000);
        rst_n = 1'b1;
        @(posedge clk); #4;

        // R7: minimum access length, normal and extra-T-state read.
        begin
            int cyc = 0;
            cfg_dw = 0; cfg_iw = 0; rmt_wait = 0; cfg_xt = 0; req_wr = 0; req = 1;
            do begin @(posedge clk); #4; cyc++; end while (!done && cyc < 20);
            req = 0;
            chk(cyc == 3, "R7 base access length", cyc, 3);
            @(posedge clk); #4;
            cyc = 0; cfg_xt = 1; req = 1;
            do begin @(posedge clk); #4; cyc++; end while (!done && cyc < 20);
            req = 0;
            chk(cyc == 4, "R7 xt read length", cyc, 4);
            @(posedge clk); #4;
        end

        // Full sweep: R2 R3 R4 R5 R6 R7 R10.
        for (int dw = 0; dw < 8; dw++)
            for (int iw = 0; iw < 8; iw++)
                for (int xt = 0; xt < 2; xt++)
                    for (int wr = 0; wr < 2; wr++)
                        run_access(wr[0], dw, iw, xt[0], (dw + iw + xt) % 4, 0, 0);

        // R8: wait held across, at and beyond the programmed length.
        for (int wl = 1; wl < 7; wl++) begin
            run_access(1'b0, 3, 0, 1'b0, 0, wl, 0);
            run_access(1'b1, 0, 0, 1'b0, 1, wl, 0);
            run_access(1'b0, 2, 5, 1'b1, 0, wl, 0);
        end

        // R9: lock blocks a pending request.
        begin
            bit quiet = 1;
            lock_n = 1'b0; req = 1'b1; req_wr = 1'b0;
            cfg_dw = 1; cfg_iw = 0; cfg_xt = 0; rmt_wait = 0;
            for (int k = 0; k < 8; k++) begin
                @(posedge clk); #4;
                if (ale || !rd_n || !wr_n || done) quiet = 0;
            end
            chk(quiet, "R9 lock blocks start", quiet, 1);
            req = 1'b0; lock_n = 1'b1;
            @(posedge clk); #4;
        end
        // R9: access under way completes when lock falls mid-strobe.
        run_access(1'b1, 4, 2, 1'b0, 1, 0, 1);
        run_access(1'b0, 4, 2, 1'b1, 0, 2, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule